// File: doc/BRIEF.md
# Text Line Shadow Refresher

This block keeps a local copy of a four-line, sixteen-column character screen. It serves a display whose character memory cannot be read back over its serial link. A user hands in one character together with its line and column. The block stores the character in its copy, then rewrites the whole line on the display. It does this because each display location packs two half-width characters, and the line start locations are not in sequence.

A rewrite is seventeen bytes on a byte stream with a valid/ready handshake. The first byte is a set-address command, flagged by the register-select output low, and it points at the start of the line. Sixteen data bytes follow, with register-select high, holding the characters of that line from column 0 to column 15. A downstream serial transmitter consumes the stream. While a rewrite is in flight, a new edit is stalled by holding its ready low, so two lines never interleave.

Top module: `textLineRefresher`

## Requirements
- R1: After reset every stored character is 0x20 (space), `outValid` is low and `editReady` is high.
- R2: `editReady` is high only while no rewrite is in progress; it is never high in a cycle where `outValid` is high.
- R3: The cycle after an edit is accepted (`editValid` and `editReady` high at a rising edge), `outValid` is high with `outRs` low, marking the address command as the first byte of the rewrite.
- R4: The address command byte is the line start location: 0x80 for line 0, 0x90 for line 1, 0x88 for line 2, 0x98 for line 3. The column part is zero because the rewrite starts at column 0 (location = line start + column / 2).
- R5: After the address command, exactly sixteen bytes with `outRs` high follow. Then `outValid` drops and `editReady` returns high.
- R6: The sixteen data bytes are the stored characters of the edited line, columns 0 to 15 in order. They include the new character and every earlier edit to that line, and edits to other lines do not change them.
- R7: While `outValid` is high and `outReady` is low, `outValid`, `outByte` and `outRs` hold their values into the next cycle.
- R8: An edit offered while a rewrite is in progress is neither stored nor shown in that rewrite. It is taken only after the rewrite ends and produces its own rewrite.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| editValid | input | 1 | An edit is offered |
| editReady | output | 1 | The block can take an edit this cycle |
| editLine | input | 2 | Line of the edited character |
| editCol | input | 4 | Column of the edited character |
| editChar | input | 8 | Character code to store |
| outValid | output | 1 | A stream byte is presented |
| outReady | input | 1 | The consumer takes the byte this cycle |
| outRs | output | 1 | 0 for the address command, 1 for character data |
| outByte | output | 8 | Stream byte |

## Verification
The hardest case to reach is an edit that arrives in the middle of a rewrite of the same line. If the block took that edit early, the character would appear one rewrite too soon, and nothing in the byte order would show it. The bench offers a second edit, to the column next to the first one, as soon as the first edit is accepted. It keeps that second edit asserted through a stalling consumer. The expected stream for the first rewrite still shows a space in that column, and the second rewrite shows both characters. All four lines, columns 0 and 15, and both a free-running and a randomly stalling consumer are covered against a model kept in the bench.

// File: rtl/textRefreshPkg.sv
package textRefreshPkg;
  typedef struct packed {
    logic capture;  // store the offered edit and latch its line
    logic clearCol; // restart the column counter
    logic stepCol;  // move to the next column
    logic selAddr;  // drive the line start location onto the stream
  } refreshStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } refreshState_t;
endpackage

// File: rtl/textLineDatapath.sv
module textLineDatapath
  import textRefreshPkg::*;
#(
  parameter int LINES  = 4,
  parameter int COLS   = 16,
  parameter int CHAR_W = 8,
  parameter logic [CHAR_W-1:0] BLANK = 8'h20,
  parameter logic [CHAR_W-1:0] ADDR_BASE = 8'h80,
  parameter logic [CHAR_W-1:0] ODD_STEP  = 8'h10,
  parameter logic [CHAR_W-1:0] HALF_STEP = 8'h08
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  refreshStrobes_t            strobes,
  input  logic [$clog2(LINES)-1:0]   editLine,
  input  logic [$clog2(COLS)-1:0]    editCol,
  input  logic [CHAR_W-1:0]          editChar,
  output logic [CHAR_W-1:0]          outByte,
  output logic                       colLast
);
  localparam int LINE_W = $clog2(LINES);
  localparam int COL_W  = $clog2(COLS);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

  logic [CHAR_W-1:0] shadow [LINES][COLS];
  logic [CHAR_W-1:0] lineBase [LINES];
  logic [LINE_W-1:0] lineReg;
  logic [COL_W-1:0]  colCnt;

  // Line start locations: odd lines sit one row step up, the upper pair
  // sits half a row further on.
  for (genvar l = 0; l < LINES; l++) begin : g_base
    assign lineBase[l] = ADDR_BASE
                       + ((l % 2) != 0 ? ODD_STEP : '0)
                       + CHAR_W'((l / 2) * int'(HALF_STEP));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int l = 0; l < LINES; l++)
        for (int c = 0; c < COLS; c++)
          shadow[l][c] <= BLANK;
      lineReg <= '0;
    end else if (strobes.capture) begin
      shadow[editLine][editCol] <= editChar;
      lineReg <= editLine;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 colCnt <= '0;
    else if (strobes.clearCol) colCnt <= '0;
    else if (strobes.stepCol)  colCnt <= colCnt + 1'b1;
  end

  assign colLast = (colCnt == LAST_COL);

  always_comb begin
    if (strobes.selAddr) outByte = lineBase[lineReg];
    else                 outByte = shadow[lineReg][colCnt];
  end
endmodule

// File: rtl/textRefreshCtrl.sv
module textRefreshCtrl
  import textRefreshPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            editValid,
  input  logic            outReady,
  input  logic            colLast,
  output logic            editReady,
  output logic            outValid,
  output logic            outRs,
  output refreshStrobes_t strobes
);
  refreshState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (editValid) stateNext = ST_ADDR;
      ST_ADDR: if (outReady)  stateNext = ST_DATA;
      ST_DATA: if (outReady && colLast) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    editReady        = (state == ST_IDLE);
    outValid         = (state != ST_IDLE);
    outRs            = (state == ST_DATA);
    strobes.capture  = (state == ST_IDLE) && editValid;
    strobes.selAddr  = (state == ST_ADDR);
    strobes.clearCol = (state == ST_ADDR) && outReady;
    strobes.stepCol  = (state == ST_DATA) && outReady;
  end
endmodule

// File: rtl/textLineRefresher.sv
module textLineRefresher
  import textRefreshPkg::*;
#(
  parameter int LINES  = 4,
  parameter int COLS   = 16,
  parameter int CHAR_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      editValid,
  output logic                      editReady,
  input  logic [$clog2(LINES)-1:0]  editLine,
  input  logic [$clog2(COLS)-1:0]   editCol,
  input  logic [CHAR_W-1:0]         editChar,
  output logic                      outValid,
  input  logic                      outReady,
  output logic                      outRs,
  output logic [CHAR_W-1:0]         outByte
);
  refreshStrobes_t strobes;
  logic colLast;

  textRefreshCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .editValid (editValid),
    .outReady  (outReady),
    .colLast   (colLast),
    .editReady (editReady),
    .outValid  (outValid),
    .outRs     (outRs),
    .strobes   (strobes)
  );

  textLineDatapath #(
    .LINES  (LINES),
    .COLS   (COLS),
    .CHAR_W (CHAR_W)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .editLine (editLine),
    .editCol  (editCol),
    .editChar (editChar),
    .outByte  (outByte),
    .colLast  (colLast)
  );
endmodule

// File: rtl/textLineRefresherChecker.sv
module textLineRefresherChecker #(
  parameter int COLS   = 16,
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              editValid,
  input logic              editReady,
  input logic              outValid,
  input logic              outReady,
  input logic              outRs,
  input logic [CHAR_W-1:0] outByte
);
  localparam int CNT_W = $clog2(COLS + 1);
  logic [CNT_W-1:0] dataCnt;

  always_ff @(posedge clk) begin
    if (!rstN) dataCnt <= CNT_W'(COLS);
    else if (outValid && outReady && !outRs) dataCnt <= '0;
    else if (outValid && outReady && outRs)  dataCnt <= dataCnt + 1'b1;
  end

  p_busy_stall_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !editReady);

  p_addr_after_accept_r3: assert property (@(posedge clk) disable iff (!rstN)
    (editValid && editReady) |=> (outValid && !outRs));

  p_addr_value_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outRs) |-> (outByte inside {8'h80, 8'h90, 8'h88, 8'h98}));

  p_data_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outRs) |-> (dataCnt < CNT_W'(COLS)));

  p_data_count_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(editReady) |-> (dataCnt == CNT_W'(COLS)));

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outByte) && $stable(outRs)));
endmodule

bind textLineRefresher textLineRefresherChecker #(
  .COLS   (COLS),
  .CHAR_W (CHAR_W)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .editValid (editValid),
  .editReady (editReady),
  .outValid  (outValid),
  .outReady  (outReady),
  .outRs     (outRs),
  .outByte   (outByte)
);

// File: tb/tb_textLineRefresher.sv
module tb_textLineRefresher;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       editValid = 1'b0;
  logic       editReady;
  logic [1:0] editLine = '0;
  logic [3:0] editCol = '0;
  logic [7:0] editChar = '0;
  logic       outValid;
  logic       outReady = 1'b1;
  logic       outRs;
  logic [7:0] outByte;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic       rs;
    logic [7:0] b;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  logic [7:0] model [4][16];
  logic [7:0] baseTab [4] = '{8'h80, 8'h90, 8'h88, 8'h98};
  logic       stallMode = 1'b0;
  logic [7:0] lfsr = 8'h5A;

  always #2 clk = ~clk; // 250 MHz

  textLineRefresher dut (
    .clk(clk), .rstN(rstN), .editValid(editValid), .editReady(editReady),
    .editLine(editLine), .editCol(editCol), .editChar(editChar),
    .outValid(outValid), .outReady(outReady), .outRs(outRs), .outByte(outByte)
  );

  // Consumer back-pressure, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    outReady <= stallMode ? (lfsr[0] ^ lfsr[3]) : 1'b1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: offers one edit, then predicts its rewrite at acceptance
  task automatic doEdit(input int ln, input int col, input logic [7:0] ch, input string tag);
    @(negedge clk);
    editValid = 1'b1; editLine = 2'(ln); editCol = 4'(col); editChar = ch;
    while (!editReady) @(negedge clk);
    model[ln][col] = ch;
    expQ.push_back('{1'b0, baseTab[ln], "R4"});
    for (int c = 0; c < 16; c++) expQ.push_back('{1'b1, model[ln][c], tag});
    @(negedge clk);
    editValid = 1'b0;
  endtask

  // Monitor: compares every accepted stream byte with the scoreboard
  logic       prevStall = 1'b0;
  logic       prevRs;
  logic [7:0] prevByte;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall) begin
        check(outValid && outByte == prevByte && outRs == prevRs, "R7",
              {outValid, outRs, outByte}, {1'b1, prevRs, prevByte});
      end
      if (outValid) check(!editReady, "R2", editReady, 0);
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R5 unexpected byte", {outRs, outByte}, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(outRs == e.rs, e.rs ? "R5" : "R3", outRs, e.rs);
          check(outByte == e.b, e.tag, outByte, e.b);
        end
      end
      prevStall = outValid && !outReady;
      prevRs    = outRs;
      prevByte  = outByte;
    end
  end

  task automatic drain();
    while (expQ.size() != 0 || !editReady) @(negedge clk);
    @(negedge clk);
    check(!outValid && editReady, "R5 idle after rewrite", {outValid, editReady}, 2'b01);
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      check(1'b0, "watchdog", cycles, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < 4; l++)
      for (int c = 0; c < 16; c++) model[l][c] = 8'h20; // R1 spaces
    repeat (3) @(negedge clk);
    check(!outValid, "R1 outValid", outValid, 0);
    check(editReady, "R1 editReady", editReady, 1);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid && editReady, "R1 after release", {outValid, editReady}, 2'b01);

    // R6: one edit per line, boundary columns, all spaces elsewhere (R1)
    doEdit(0, 0, 8'h41, "R6"); drain();
    doEdit(1, 15, 8'h42, "R6"); drain();
    doEdit(2, 7, 8'h43, "R6"); drain();
    doEdit(3, 8, 8'h44, "R6"); drain();
    // accumulation on one line
    doEdit(0, 15, 8'h5A, "R6"); drain();
    doEdit(0, 1, 8'h61, "R6"); drain();

    // Under random back-pressure (R7)
    stallMode = 1'b1;
    for (int i = 0; i < 12; i++) begin
      doEdit(i % 4, (i * 5) % 16, 8'(8'h30 + i), "R6");
      drain();
    end

    // R8: second edit offered while the first rewrite is running
    doEdit(2, 5, 8'h58, "R8");
    doEdit(2, 6, 8'h59, "R8");
    drain();
    stallMode = 1'b0;
    doEdit(3, 3, 8'h7E, "R8");
    doEdit(3, 4, 8'h7F, "R8");
    drain();

    check(expQ.size() == 0, "R5 scoreboard empty", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule